// File: doc/BRIEF.md
# Input Change Interrupt Controller

This block watches a bank of input lines and records every level change on each of them. Each clock it compares the current value of every line with the value it held one clock earlier. A difference sets a sticky pending bit for that line. The value compared per line is either the raw pin level or an already de-glitched copy of it, chosen by a per-line filter-select bit. Detection runs on every line whatever that line is used for elsewhere: a plain input, a driven output, or a pin owned by a peripheral.

A mask decides which pending lines may raise the single interrupt output. Software never writes the mask as a whole word. It pulses ones on a set port to enable lines and ones on a clear port to disable them. A read strobe on the status port hands back all pending bits and clears every one of them at the next edge. A change detected in that same cycle survives the clear, so no event is lost.

Top module: `ichg_irq`

## Requirements
- R1: After reset, `stat_q`, `mask_q` and `irq` are all 0. The previous-sample register is loaded from the current selected input while reset is held, so a nonzero input level at reset release sets no status bit.
- R2: A change of a line's selected value sets that line's bit in `stat_q` at the next rising clock edge. Both rising and falling changes count, and several lines may change in the same cycle. The bit then stays set until a status read.
- R3: Status bits are set whether or not the line's mask bit is set.
- R4: At a clock edge, each 1 bit on `mask_set` sets the matching `mask_q` bit and each 1 bit on `mask_clr` clears it. Zero bits leave the mask unchanged. When both ports carry a 1 on the same bit, the clear wins.
- R5: `irq` is high exactly when some bit is set in both `stat_q` and `mask_q`.
- R6: While `stat_rd` is high, `stat_q` presents every pending bit. At the edge that ends that cycle, all status bits are cleared.
- R7: A change detected at the same edge as a status read leaves its bit set after the clear.
- R8: When bit i of `filt_en` is 1, line i is detected from `line_filt[i]` and changes on `line_raw[i]` are ignored. When bit i of `filt_en` is 0, line i is detected from `line_raw[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_raw | input | NLINES | Unfiltered line levels |
| line_filt | input | NLINES | De-glitched line levels |
| filt_en | input | NLINES | Per-line select of the filtered level |
| mask_set | input | NLINES | Write-one-to-enable mask pulses |
| mask_clr | input | NLINES | Write-one-to-disable mask pulses |
| stat_rd | input | 1 | Status read strobe, clears all pending bits |
| stat_q | output | NLINES | Pending change bits |
| mask_q | output | NLINES | Current interrupt mask |
| irq | output | 1 | OR of pending and unmasked lines |

## Verification
The bench releases reset with many lines already high. A design that fails to preload the previous sample would then flag spurious changes. It issues a status read in the same cycle as a new edge, which catches a clear that wipes out the fresh event. It drives set and clear on the same mask bit, which exposes a design that lets the set win. It also moves the raw pin of a filtered line and confirms that nothing is latched, which would go wrong if the select were ignored or inverted. Lines changing while masked confirm that pending bits still accumulate while `irq` stays quiet.

// File: rtl/ichg_irq.sv
module ichg_irq #(
  parameter int NLINES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] line_raw,
  input  logic [NLINES-1:0] line_filt,
  input  logic [NLINES-1:0] filt_en,
  input  logic [NLINES-1:0] mask_set,
  input  logic [NLINES-1:0] mask_clr,
  input  logic              stat_rd,
  output logic [NLINES-1:0] stat_q,
  output logic [NLINES-1:0] mask_q,
  output logic              irq
);

  logic [NLINES-1:0] sel_lvl;
  logic [NLINES-1:0] last_lvl;
  logic [NLINES-1:0] edge_hit;

  assign sel_lvl  = (line_filt & filt_en) | (line_raw & ~filt_en);
  assign edge_hit = sel_lvl ^ last_lvl;

  always_ff @(posedge clk) begin
    last_lvl <= sel_lvl;
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      stat_q <= (stat_rd ? '0 : stat_q) | edge_hit;
      mask_q <= (mask_q | mask_set) & ~mask_clr;
    end
  end

  assign irq = |(stat_q & mask_q);

endmodule

// File: rtl/ichg_irq_chk.sv
module ichg_irq_chk #(
  parameter int NLINES = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NLINES-1:0] line_raw,
  input logic [NLINES-1:0] line_filt,
  input logic [NLINES-1:0] filt_en,
  input logic [NLINES-1:0] mask_set,
  input logic [NLINES-1:0] mask_clr,
  input logic              stat_rd,
  input logic [NLINES-1:0] stat_q,
  input logic [NLINES-1:0] mask_q,
  input logic              irq
);

  logic [NLINES-1:0] lvl_c;
  assign lvl_c = filt_en ? ((line_filt & filt_en) | (line_raw & ~filt_en)) : line_raw;

  // R2 / R8: a change of the selected level is latched at the next edge
  p_edge_latched_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |=> ((stat_q & ($past(lvl_c) ^ $past(lvl_c, 2))) == ($past(lvl_c) ^ $past(lvl_c, 2))));

  // R6 / R7: after a read only the changes seen at that edge remain
  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && stat_rd) |=> (stat_q == ($past(lvl_c) ^ $past(lvl_c, 2))));

  // R4: clear bits always end up low
  p_clr_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_clr != '0) |=> ((mask_q & $past(mask_clr)) == '0));

  // R4: set bits without clear end up high
  p_set_takes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask_set & ~mask_clr) != '0) |=> ((mask_q & $past(mask_set & ~mask_clr)) == $past(mask_set & ~mask_clr)));

  // R4: no write, no mask movement
  p_mask_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_set == '0 && mask_clr == '0) |=> $stable(mask_q));

  // R5: a quiet read leaves nothing to interrupt on
  p_quiet_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && stat_rd && (lvl_c == $past(lvl_c))) |=> !irq);

endmodule

bind ichg_irq ichg_irq_chk #(.NLINES(NLINES)) u_chk (.*);

// File: tb/tb_ichg_irq.sv
module tb_ichg_irq;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] line_raw = '0, line_filt = '0, filt_en = '0, mask_set = '0, mask_clr = '0;
  logic        stat_rd = 1'b0;
  logic [31:0] stat_q, mask_q;
  logic        irq;

  ichg_irq #(.NLINES(32)) dut (.*);

  always #(CLK_P/2) clk = ~clk;

  typedef struct packed {
    logic [31:0] st;
    logic [31:0] mk;
    logic        iq;
    logic [7:0]  rq;
  } exp_t;

  exp_t sb[$];
  int n_run = 0, n_fail = 0;
  logic [31:0] m_prev = '0, m_stat = '0, m_mask = '0;
  bit done = 0;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input int rq, input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus and queue what must follow the edge
  task automatic step(input logic [31:0] raw, input logic [31:0] filt, input logic [31:0] fen,
                      input logic [31:0] ms, input logic [31:0] mc, input logic rd, input int rq);
    logic [31:0] lvl;
    exp_t e;
    @(negedge clk);
    line_raw = raw; line_filt = filt; filt_en = fen;
    mask_set = ms; mask_clr = mc; stat_rd = rd;
    #1;
    if (rd) chk(stat_q, m_stat, 6, "read value"); // R6
    lvl = (filt & fen) | (raw & ~fen);
    m_stat = (rd ? 32'h0 : m_stat) | (lvl ^ m_prev);
    m_mask = (m_mask | ms) & ~mc;
    m_prev = lvl;
    e.st = m_stat; e.mk = m_mask; e.iq = |(m_stat & m_mask); e.rq = 8'(rq);
    sb.push_back(e);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk(stat_q, e.st, int'(e.rq), "status");
        chk(mask_q, e.mk, int'(e.rq), "mask");
        chk({31'h0, irq}, {31'h0, e.iq}, int'(e.rq), "irq");
      end
    end
  end

  initial begin
    #(CLK_P * 5000);
    if (!done) begin
      n_fail++;
      $display("FAIL R0 watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    r = 32'hA5A5_0F0F;
    line_raw = r; line_filt = r;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_prev = r;
    #1;
    // R1: reset state
    chk(stat_q, 32'h0, 1, "reset status");
    chk(mask_q, 32'h0, 1, "reset mask");
    chk({31'h0, irq}, 32'h0, 1, "reset irq");
    step(r, r, 0, 0, 0, 0, 1);                        // R1: no spurious change
    step(r, r, 0, 32'h0000_00FF, 0, 0, 4);            // R4: enable low byte
    r = r ^ 32'h1;
    step(r, r, 0, 0, 0, 0, 2);                        // R2/R5: falling edge on masked-in line
    r = r ^ 32'h0010_0000;
    step(r, r, 0, 0, 0, 0, 3);                        // R3: masked-off line still pends
    step(r, r, 0, 0, 0, 0, 2);                        // R2: sticky
    step(r, r, 0, 0, 0, 1, 6);                        // R6: read and clear
    r = r ^ 32'h0010_0000;
    step(r, r, 0, 0, 0, 0, 5);                        // R5: pending but masked, no irq
    r = r ^ 32'h8;
    step(r, r, 0, 0, 0, 1, 7);                        // R7: change during read survives
    step(r, r, 0, 32'h18, 32'h8, 0, 4);               // R4: clear beats set on bit 3
    step(r, r, 0, 0, 32'h0000_00F0, 1, 4);            // R4/R5: disable and read
    step(r, r, 32'h100, 0, 0, 0, 8);                  // R8: switch to filtered copy, same level
    step(r ^ 32'h100, r, 32'h100, 32'h100, 0, 0, 8);  // R8: raw moves, ignored
    step(r ^ 32'h100, r ^ 32'h100, 32'h100, 0, 0, 0, 8); // R8: filtered moves, seen
    step(r ^ 32'h100, r ^ 32'h100, 32'h100, 0, 0, 1, 6); // R6: clear
    r = r ^ 32'hF000_0003;
    step(r, r, 0, 32'hFFFF_FFFF, 0, 0, 2);            // R2: several lines, both polarities
    step(r, r, 0, 0, 32'hFFFF_FFFF, 0, 5);            // R5: all masked off, irq drops
    step(r, r, 0, 0, 0, 1, 6);
    repeat (2) @(posedge clk);
    #2;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule